// File: doc/BRIEF.md
# Set-Associative Cache Controller with Shared Round-Robin Victim Pointer

This block holds the tag and valid state of a 4-way set-associative cache with 128 sets and 16-byte lines. It serves instruction fetches and data accesses through one request port, so the two streams compete for the same lines and can evict each other. For each accepted request it looks up the set and reports a hit with its way. On a miss it picks a way, requests a line fill from memory and reports the miss when the fill completes. Line data and write policy are handled elsewhere.

Victims are chosen by a single 2-bit pointer shared by every set. The pointer is used and advanced only when a miss lands in a set whose ways are all valid. Hits do not touch it, and neither do misses that find a free way. Only one miss is in flight at a time, and the request port stalls until its fill finishes.

Top module: `rr_cache_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and fill_req are 0, every line is invalid (the first access to any address misses) and the victim pointer is 0.
- R2: Address bits [3:0] select a byte within the line and do not affect the lookup. Bits [10:4] select the set and bits [31:11] form the tag.
- R3: A hit is answered in the cycle after acceptance with resp_hit=1 and resp_way set to the way holding the line. The victim pointer is unchanged.
- R4: A miss in a set with at least one invalid way allocates the lowest-numbered invalid way. The victim pointer is unchanged.
- R5: A miss in a set whose 4 ways are all valid replaces the way whose number equals the victim pointer. The pointer then increments modulo 4.
- R6: One victim pointer serves all sets, so a replacement in one set moves the choice made in every other set.
- R7: After a miss is accepted, fill_req is high for exactly MISS_CYCLES cycles (default 8, intended range 6 to 9), starting in the cycle after acceptance. Throughout those cycles fill_line carries address bits [31:4]. In the cycle after fill_req falls, resp_valid is 1 with resp_hit=0 and the allocated way.
- R8: req_ready is 0 whenever a fill is outstanding. A request presented then is ignored: it produces no response and leaves no line behind.
- R9: Each accepted request produces exactly one resp_valid cycle. A request accepted in the cycle that carries a miss response sees the line just filled and the pointer already updated.
- R10: Starting from reset, accessing blocks 0 to 511 in order fills every line with the pointer still 0. Blocks 512, 513, 514, 515 and 516 then replace way 0, 1, 2, 3 and 0 of sets 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Controller can accept a request this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 for hit, 0 for miss |
| resp_way | output | log2(WAYS) | Way that holds or received the line |
| fill_req | output | 1 | Line fill in progress |
| fill_line | output | ADDR_W-log2(LINE_BYTES) | Line address being filled |

## Verification
The cycle that ends a fill is also the first cycle in which the port is ready again. In that single cycle the miss response, the tag write, the pointer step and the lookup of the next request all meet. The bench provokes this by presenting the next request exactly in the miss response cycle. This is done both for a hit to the line just filled and for a further replacement in the same set. A reference model judges it cycle by cycle: it expects the new request to see the written tag and the advanced pointer, and it expects every response strobe in its predicted cycle.

// File: rtl/rr_cache_pkg.sv
package rr_cache_pkg;
  typedef enum logic [0:0] {
    CTRL_IDLE = 1'b0,
    CTRL_FILL = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/rrc_tag_store.sv
module rrc_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  input  logic [TAG_W-1:0]         rd_tag,
  output logic [WAYS-1:0]          hit_vec,
  output logic [WAYS-1:0]          valid_vec,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic [$clog2(WAYS)-1:0]  wr_way,
  input  logic [TAG_W-1:0]         wr_tag
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  assign valid_vec = valid_q[rd_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
  end
endmodule

// File: rtl/rrc_victim_pick.sv
module rrc_victim_pick #(
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAYS-1:0]          valid_vec,
  input  logic                     bump,
  output logic [$clog2(WAYS)-1:0]  pick_way,
  output logic                     pick_full,
  output logic [$clog2(WAYS)-1:0]  rr_ptr
);
  localparam int WAY_W = $clog2(WAYS);

  // Lowest free way wins; with no free way the shared pointer decides.
  always_comb begin
    pick_full = 1'b1;
    pick_way  = rr_ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        pick_way  = WAY_W'(w);
        pick_full = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rr_ptr <= '0;
    else if (bump) rr_ptr <= rr_ptr + 1'b1;
  end
endmodule

// File: rtl/rrc_fill_timer.sv
module rrc_fill_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rr_cache_ctrl.sv
module rr_cache_ctrl
  import rr_cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 128,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int MISS_CYCLES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic [ADDR_W-1:0]                      req_addr,
  output logic                                   req_ready,
  output logic                                   resp_valid,
  output logic                                   resp_hit,
  output logic [$clog2(WAYS)-1:0]                resp_way,
  output logic                                   fill_req,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   fill_line
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFS_W - SET_W;
  localparam int LIN_W = ADDR_W - OFS_W;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // Internal events, named for the checker.
  logic accept, evt_hit, evt_miss, evt_alloc, evt_replace, fill_done, fill_busy;

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_vec, valid_vec;
  logic             hit_any, pick_full;
  logic [WAY_W-1:0] hit_way, pick_way, rr_ptr;
  logic             unused_ofs;

  ctrl_state_e      state_q;
  logic [SET_W-1:0] pend_set;
  logic [TAG_W-1:0] pend_tag;
  logic [WAY_W-1:0] pend_way;
  logic             pend_full;
  logic [LIN_W-1:0] fill_line_q;

  assign lk_set     = set_of(req_addr);
  assign lk_tag     = tag_of(req_addr);
  assign unused_ofs = ^req_addr[OFS_W-1:0];

  assign hit_any = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign req_ready   = (state_q == CTRL_IDLE);
  assign accept      = req_valid && req_ready;
  assign evt_hit     = accept && hit_any;
  assign evt_miss    = accept && !hit_any;
  assign evt_replace = fill_done && pend_full;
  assign evt_alloc   = fill_done && !pend_full;
  assign fill_req    = fill_busy;
  assign fill_line   = fill_line_q;

  rrc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_set(lk_set), .rd_tag(lk_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .wr_en(fill_done), .wr_set(pend_set), .wr_way(pend_way), .wr_tag(pend_tag)
  );

  rrc_victim_pick #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_vec), .bump(evt_replace),
    .pick_way(pick_way), .pick_full(pick_full), .rr_ptr(rr_ptr)
  );

  rrc_fill_timer #(.CYCLES(MISS_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(evt_miss), .busy(fill_busy), .done(fill_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= CTRL_IDLE;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_way    <= '0;
      pend_set    <= '0;
      pend_tag    <= '0;
      pend_way    <= '0;
      pend_full   <= 1'b0;
      fill_line_q <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (evt_hit) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        resp_way   <= hit_way;
      end else if (evt_miss) begin
        state_q     <= CTRL_FILL;
        pend_set    <= lk_set;
        pend_tag    <= lk_tag;
        pend_way    <= pick_way;
        pend_full   <= pick_full;
        fill_line_q <= req_addr[ADDR_W-1:OFS_W];
      end else if (fill_done) begin
        state_q    <= CTRL_IDLE;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        resp_way   <= pend_way;
      end
    end
  end
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             fill_req,
  input logic             evt_hit,
  input logic             evt_alloc,
  input logic             evt_replace,
  input logic [WAY_W-1:0] rr_ptr
);
  // R1: first cycle out of reset is idle
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !resp_valid && !fill_req && rr_ptr == '0));

  // R3: hit leaves the shared pointer alone
  a_r3_hit_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> $stable(rr_ptr));

  // R3: a hit response follows an accepted request by one cycle
  a_r3_hit_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(req_valid && req_ready));

  // R4: fill into a free way leaves the pointer alone
  a_r4_alloc_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alloc |=> $stable(rr_ptr));

  // R5: replacement steps the pointer by one, wrapping
  a_r5_replace_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_replace |=> (rr_ptr == WAY_W'($past(rr_ptr) + 1'b1)));

  // R7: the miss response comes right after the fill window closes
  a_r7_resp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_req) |-> (resp_valid && !resp_hit));

  // R8: port stalls while a fill is outstanding
  a_r8_not_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  // R8: no response strobe inside a fill window
  a_r8_quiet_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && $past(fill_req)) |-> !resp_valid);

  // R9: every miss response has a fill behind it
  a_r9_miss_resp_has_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(fill_req));
endmodule

bind rr_cache_ctrl rrc_checker #(.WAY_W(WAY_W)) u_rrc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .fill_req(fill_req),
  .evt_hit(evt_hit), .evt_alloc(evt_alloc), .evt_replace(evt_replace),
  .rr_ptr(rr_ptr)
);

// File: tb/test_rr_cache_ctrl.sv
module test_rr_cache_ctrl;
  localparam int MISS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_valid, resp_hit, fill_req;
  logic [1:0]  resp_way;
  logic [27:0] fill_line;

  rr_cache_ctrl #(.MISS_CYCLES(MISS)) i_rr_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .fill_req(fill_req), .fill_line(fill_line)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit chk_on = 0;

  always @(posedge clk) cyc = cyc + 1;

  // Reference model: plain arrays and a counter.
  bit          mv [128][4];
  int unsigned mt [128][4];
  int          mctr;
  int          fill_lo = 1, fill_hi = 0;
  logic [27:0] exp_line;
  int          rq_cyc [$];
  bit          rq_hit [$];
  int          rq_way [$];

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_access(input int unsigned a, output bit h, output int w);
    int s = int'((a / 16) % 128);
    int unsigned t = a / 2048;
    h = 0; w = -1;
    for (int i = 0; i < 4; i++)
      if (!h && mv[s][i] && mt[s][i] == t) begin h = 1; w = i; end
    if (!h) begin
      for (int i = 3; i >= 0; i--) if (!mv[s][i]) w = i;
      if (w < 0) begin w = mctr; mctr = (mctr + 1) % 4; end
      mv[s][w] = 1; mt[s][w] = t;
    end
  endtask

  // Per-cycle comparison against the model's expectations.
  always @(negedge clk) begin
    if (chk_on) begin
      bit bad, efill, erv;
      bad = 0;
      efill = (cyc >= fill_lo) && (cyc <= fill_hi);
      erv = (rq_cyc.size() > 0) && (rq_cyc[0] == cyc);
      checks++;
      if (fill_req !== efill) begin bad = 1;
        $display("FAIL R7 fill_req actual=%0b expected=%0b cyc=%0d", fill_req, efill, cyc); end
      if (req_ready !== !efill) begin bad = 1;
        $display("FAIL R8 req_ready actual=%0b expected=%0b cyc=%0d", req_ready, !efill, cyc); end
      if (efill && fill_line !== exp_line) begin bad = 1;
        $display("FAIL R7 fill_line actual=%0h expected=%0h cyc=%0d", fill_line, exp_line, cyc); end
      if (resp_valid !== erv) begin bad = 1;
        $display("FAIL R9 resp_valid actual=%0b expected=%0b cyc=%0d", resp_valid, erv, cyc); end
      if (erv) begin
        if (resp_hit !== rq_hit[0] || int'(resp_way) != rq_way[0]) begin bad = 1;
          $display("FAIL R3 R4 R5 hit/way actual=%0b/%0d expected=%0b/%0d cyc=%0d",
                   resp_hit, resp_way, rq_hit[0], rq_way[0], cyc); end
        void'(rq_cyc.pop_front()); void'(rq_hit.pop_front()); void'(rq_way.pop_front());
      end else if (rq_cyc.size() > 0 && rq_cyc[0] < cyc) begin
        bad = 1;
        $display("FAIL R9 response missing actual=0 expected=1 cyc=%0d", rq_cyc[0]);
        void'(rq_cyc.pop_front()); void'(rq_hit.pop_front()); void'(rq_way.pop_front());
      end
      if (bad) failures++;
    end
  end

  task automatic apply_reset();
    chk_on = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    rq_cyc.delete(); rq_hit.delete(); rq_way.delete();
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    mctr = 0; fill_lo = 1; fill_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
  endtask

  // Called at a negedge; waits for the model's ready, drives one cycle.
  task automatic issue(input int unsigned a);
    bit h; int w; int acc;
    while (cyc <= fill_hi) @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    model_access(a, h, w);
    acc = cyc + 1;
    if (h) begin
      rq_cyc.push_back(acc); rq_hit.push_back(1'b1); rq_way.push_back(w);
    end else begin
      fill_lo = acc; fill_hi = acc + MISS - 1;
      exp_line = 28'(a / 16);
      rq_cyc.push_back(acc + MISS); rq_hit.push_back(1'b0); rq_way.push_back(w);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic access_chk(input int unsigned a, input bit eh, input int ew, input string req);
    issue(a);
    while (resp_valid !== 1'b1) @(negedge clk);
    check_eq(req, "resp_hit", int'(resp_hit), int'(eh));
    check_eq(req, "resp_way", int'(resp_way), ew);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    apply_reset();
    // R1 reset state
    check_eq("R1", "req_ready", int'(req_ready), 1);
    check_eq("R1", "resp_valid", int'(resp_valid), 0);
    check_eq("R1", "fill_req", int'(fill_req), 0);
    access_chk(32'h0000, 0, 0, "R1");          // empty cache misses
    access_chk(32'h0009, 1, 0, "R2");          // offset ignored
    access_chk(32'h0800, 0, 1, "R4");          // block 128, set 0
    access_chk(32'h0810, 0, 0, "R2");          // block 129 is set 1
    access_chk(32'h1000, 0, 2, "R4");
    access_chk(32'h1800, 0, 3, "R4");
    access_chk(32'h080F, 1, 1, "R3");
    access_chk(32'h2000, 0, 0, "R5");          // full set, pointer 0 -> 1
    access_chk(32'h2800, 0, 1, "R5");          // pointer 1 -> 2
    // R8: request during a fill is ignored
    issue(32'h3000);                           // replaces way 2, pointer -> 3
    req_valid = 1'b1; req_addr = 32'h0010;     // block 1, while busy
    @(negedge clk);
    req_valid = 1'b0;
    while (resp_valid !== 1'b1) @(negedge clk);
    check_eq("R8", "resp_hit after ignored req", int'(resp_hit), 0);
    access_chk(32'h0010, 0, 1, "R8");          // still absent, lowest free way
    access_chk(32'h2000, 1, 0, "R3");          // hit, pointer stays 3
    access_chk(32'h3800, 0, 3, "R5");          // pointer 3 -> 0
    access_chk(32'h4000, 0, 0, "R5");          // wrap, pointer -> 1
    access_chk(32'h1010, 0, 2, "R4");
    access_chk(32'h1810, 0, 3, "R4");
    access_chk(32'h2010, 0, 1, "R6");          // set 1 uses shared pointer 1
    // R9: back-to-back in the miss response cycle
    access_chk(32'h4800, 0, 2, "R9");
    access_chk(32'h4804, 1, 2, "R9");
    // R7: fill length
    issue(32'h0020);
    n = 0;
    while (resp_valid !== 1'b1) begin
      if (fill_req) n++;
      @(negedge clk);
    end
    check_eq("R7", "fill cycles", n, MISS);
    check_eq("R7", "miss way", int'(resp_way), 0);

    // R10: startup sequence after a fresh reset
    apply_reset();
    check_eq("R1", "req_ready", int'(req_ready), 1);
    for (int b = 0; b < 512; b++) access_chk(32'(b * 16), 0, b / 128, "R10");
    access_chk(32'(512 * 16), 0, 0, "R10");
    access_chk(32'(513 * 16), 0, 1, "R10");
    access_chk(32'(514 * 16), 0, 2, "R10");
    access_chk(32'(515 * 16), 0, 3, "R10");
    access_chk(32'(516 * 16), 0, 0, "R10");
    access_chk(32'(1 * 16), 1, 0, "R3");
    access_chk(32'(129 * 16), 0, 1, "R5");     // evicted by 513, pointer 1
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule